// File: doc/BRIEF.md
# Tagged Word Memory Controller

This block is a word-organised store that serves a small processor core. Callers give it byte addresses. Every word also holds a two-bit content tag, which records whether the word is undefined, a format-A instruction, a format-B instruction or data. The core sends one request at a time over a valid/ready handshake. A request is one of: fetch the instruction at the internal instruction counter, load the counter, load a word, load a byte, store a word or store a byte. Fetches and loads return their data one cycle after the request is accepted.

The controller enforces the tags. A fetch succeeds only on an instruction-tagged word, and a store may never overwrite an instruction. It also rejects addresses that are out of range and word accesses that are not aligned to four bytes. It keeps a memory address register and a memory data register, and it counts memory cycles with a cost model: a load that reuses the last recorded word index is cheap, and any other memory access is expensive. Any fault produces a one-cycle pulse with a code and halts the controller until reset. A separate preload port writes words and their tags during initialisation.

Top module: `tagmem_ctrl`

## Requirements
- R1: After reset, every word reads as zero and is tagged undefined. The instruction counter is all ones, the cycle count is zero, `halted` is low, `req_ready` is high and `rsp_valid` is low. A fetch issued straight after reset takes an address fault, because the counter is all ones.
- R2: Request code 5 loads `req_addr` into the instruction counter. Request code 0 fetches the word at the counter. When that word is tagged 1 (format A) or 2 (format B), the fetch returns the word, adds 4 to the counter and adds 10 to the cycle count.
- R3: A fetch of a word tagged 0 (undefined) or 3 (data) raises fault code 2 and returns zero.
- R4: Fault code 0 is raised, with no memory access, when address bit 31 is set or when the word index (the address shifted right by two) is at or above DEPTH. This check takes priority over every other check.
- R5: A word load (code 1) or word store (code 3) whose address has a nonzero bit 1 or bit 0 raises fault code 1. A byte load (code 2) has no alignment rule.
- R6: When a word or byte load targets the word index held in the address register, it adds 1 to the cycle count. Any other load adds 10 and records the new index in the address register.
- R7: A word load that hits the recorded index returns the contents of the data register, not the array. If a byte store has changed the word since it was last captured, the load returns the old value.
- R8: A byte load returns the addressed byte zero-extended. Byte lane n is bits 8n+7 down to 8n of the word. The byte load also refreshes the data register from the array.
- R9: A word store or byte store (code 4) to a word tagged 1 or 2 raises fault code 3 and adds no cycles.
- R10: A successful word store writes the word and tags it as data. It sets the address register to the word's index and the data register to the stored value, and it adds 10 cycles.
- R11: A successful byte store changes only the addressed lane and tags the word as data. On a word that was undefined, the other lanes read as zero afterwards. A byte store leaves the address register unchanged and adds no cycles.
- R12: A fault drives `fault_pulse` high for exactly one cycle, with `fault_code` alongside. It sets `halted`, which holds `req_ready` low and blocks every later request until reset.
- R13: While `pre_valid` is high, the preload port writes `pre_word` and `pre_tag` to word index `pre_index`, and `req_ready` is low, so no request is accepted in that cycle.
- R14: `rsp_valid` pulses for one cycle, in the cycle after an accepted fetch or load. Stores and counter loads produce no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_op | input | 3 | 0 fetch, 1 word load, 2 byte load, 3 word store, 4 byte store, 5 load counter |
| req_addr | input | 32 | Byte address, or the new counter value |
| req_wdata | input | 32 | Store data (byte store uses bits 7:0) |
| pre_valid | input | 1 | Preload write strobe |
| pre_index | input | IDX_W | Preload word index |
| pre_word | input | 32 | Preload word |
| pre_tag | input | 2 | Preload tag: 0 undefined, 1 format A, 2 format B, 3 data |
| rsp_valid | output | 1 | Response data valid |
| rsp_data | output | 32 | Fetched or loaded data, zero on a fault |
| fault_pulse | output | 1 | One-cycle fault indication |
| fault_code | output | 2 | 0 range, 1 alignment, 2 illegal fetch, 3 overwrite |
| halted | output | 1 | Sticky halt after a fault |
| instr_ctr | output | 32 | Instruction counter |
| cycle_count | output | CNT_W | Accumulated memory cycles |

## Verification
The bench targets the stale-data corner. A byte store lands on the word the data register already holds, and a word load hit must then return the old value, while a byte load must refresh the register. A design that read the array on every hit, or that let a byte store move the address register, would show a different word or a cycle count that is out by 9.

It also probes the range boundary at the last valid word and one word past it, the priority of the range fault over the alignment fault, and byte loads at unaligned addresses that must not fault. A design that got these wrong would raise a fault where none is due, or return the wrong code.

Fault cases check that the pulse lasts one cycle and that later requests are ignored. A wrong design would keep responding after a fault, or would let a store to an instruction word add cycles.

// File: rtl/tagmem_pkg.sv
package tagmem_pkg;

    localparam int WORD_W     = 32;
    localparam int FETCH_COST = 10;
    localparam int MISS_COST  = 10;
    localparam int HIT_COST   = 1;
    localparam int STORE_COST = 10;

    typedef enum logic [1:0] {
        TAG_UNDEF = 2'd0,
        TAG_FMTA  = 2'd1,
        TAG_FMTB  = 2'd2,
        TAG_DATA  = 2'd3
    } tag_e;

    typedef enum logic [2:0] {
        OP_FETCH = 3'd0,
        OP_LDW   = 3'd1,
        OP_LDB   = 3'd2,
        OP_STW   = 3'd3,
        OP_STB   = 3'd4,
        OP_SETPC = 3'd5,
        OP_RSV6  = 3'd6,
        OP_RSV7  = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        FLT_RANGE     = 2'd0,
        FLT_ALIGN     = 2'd1,
        FLT_ILLEGAL   = 2'd2,
        FLT_OVERWRITE = 2'd3
    } flt_e;

    typedef struct packed {
        logic fault;
        flt_e code;
        logic hit;
    } verdict_t;

    function automatic logic is_instr(tag_e t);
        return (t == TAG_FMTA) || (t == TAG_FMTB);
    endfunction

    function automatic logic [WORD_W-1:0] lane_merge(logic [WORD_W-1:0] w,
                                                     logic [1:0] lane,
                                                     logic [7:0] b);
        logic [WORD_W-1:0] r;
        r = w;
        r[8*lane +: 8] = b;
        return r;
    endfunction

    function automatic logic [7:0] lane_pick(logic [WORD_W-1:0] w, logic [1:0] lane);
        return w[8*lane +: 8];
    endfunction

endpackage

// File: rtl/tagmem_array.sv
module tagmem_array
    import tagmem_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_word,
    output tag_e              rd_tag,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_word,
    input  tag_e              wr_tag
);

    logic [WORD_W-1:0] data_q [DEPTH];
    tag_e              tag_q  [DEPTH];

    logic rd_in, wr_in;
    assign rd_in = 32'(rd_idx) < 32'(DEPTH);
    assign wr_in = 32'(wr_idx) < 32'(DEPTH);

    always_comb begin
        rd_tag  = TAG_UNDEF;
        rd_word = '0;
        if (rd_in) begin
            rd_tag = tag_q[rd_idx];
            if (tag_q[rd_idx] != TAG_UNDEF)
                rd_word = data_q[rd_idx];
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en && wr_in)
            data_q[wr_idx] <= wr_word;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++)
                tag_q[i] <= TAG_UNDEF;
        end else if (wr_en && wr_in) begin
            tag_q[wr_idx] <= wr_tag;
        end
    end

endmodule

// File: rtl/tagmem_rules.sv
module tagmem_rules
    import tagmem_pkg::*;
#(
    parameter int DEPTH = 1024
) (
    input  op_e         op,
    input  logic [31:0] addr,
    input  tag_e        tag,
    input  logic [29:0] mar,
    output verdict_t    verdict
);

    logic [29:0] idx;
    logic        out_range, misalign, instr;

    assign idx       = addr[31:2];
    assign out_range = addr[31] || (32'(idx) >= 32'(DEPTH));
    assign misalign  = addr[1:0] != 2'b00;
    assign instr     = is_instr(tag);

    always_comb begin
        verdict.fault = 1'b0;
        verdict.code  = FLT_RANGE;
        verdict.hit   = (idx == mar);
        unique case (op)
            OP_FETCH: begin
                if (out_range)  begin verdict.fault = 1'b1; verdict.code = FLT_RANGE;   end
                else if (!instr) begin verdict.fault = 1'b1; verdict.code = FLT_ILLEGAL; end
            end
            OP_LDW: begin
                if (out_range)     begin verdict.fault = 1'b1; verdict.code = FLT_RANGE; end
                else if (misalign) begin verdict.fault = 1'b1; verdict.code = FLT_ALIGN; end
            end
            OP_LDB: begin
                if (out_range) begin verdict.fault = 1'b1; verdict.code = FLT_RANGE; end
            end
            OP_STW: begin
                if (out_range)     begin verdict.fault = 1'b1; verdict.code = FLT_RANGE;     end
                else if (misalign) begin verdict.fault = 1'b1; verdict.code = FLT_ALIGN;     end
                else if (instr)    begin verdict.fault = 1'b1; verdict.code = FLT_OVERWRITE; end
            end
            OP_STB: begin
                if (out_range)  begin verdict.fault = 1'b1; verdict.code = FLT_RANGE;     end
                else if (instr) begin verdict.fault = 1'b1; verdict.code = FLT_OVERWRITE; end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/tagmem_ctrl.sv
module tagmem_ctrl
    import tagmem_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int IDX_W = $clog2(DEPTH),
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [2:0]       req_op,
    input  logic [31:0]      req_addr,
    input  logic [31:0]      req_wdata,
    input  logic             pre_valid,
    input  logic [IDX_W-1:0] pre_index,
    input  logic [31:0]      pre_word,
    input  logic [1:0]       pre_tag,
    output logic             rsp_valid,
    output logic [31:0]      rsp_data,
    output logic             fault_pulse,
    output logic [1:0]       fault_code,
    output logic             halted,
    output logic [31:0]      instr_ctr,
    output logic [CNT_W-1:0] cycle_count
);

    op_e               op;
    logic              acc, ok;
    logic [31:0]       eff_addr;
    logic [IDX_W-1:0]  acc_idx;
    logic [1:0]        lane;
    logic [WORD_W-1:0] rd_word;
    tag_e              rd_tag;
    verdict_t          v;

    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;
    logic [WORD_W-1:0] wr_word;
    tag_e              wr_tag;

    logic              rsp_valid_q, flt_q, halted_q;
    logic [31:0]       rsp_data_q, ic_q;
    flt_e              code_q;
    logic [29:0]       mar_q;
    logic [WORD_W-1:0] mdr_q, rsp_next;
    logic [CNT_W-1:0]  cyc_q;
    logic [3:0]        cost;

    assign op        = op_e'(req_op);
    assign req_ready = !halted_q && !pre_valid;
    assign acc       = req_valid && req_ready;
    assign eff_addr  = (op == OP_FETCH) ? ic_q : req_addr;
    assign acc_idx   = eff_addr[IDX_W+1:2];
    assign lane      = eff_addr[1:0];
    assign ok        = acc && !v.fault;

    tagmem_array #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_array (
        .clk     (clk),
        .rst     (rst),
        .rd_idx  (acc_idx),
        .rd_word (rd_word),
        .rd_tag  (rd_tag),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_word (wr_word),
        .wr_tag  (wr_tag)
    );

    tagmem_rules #(.DEPTH(DEPTH)) u_rules (
        .op      (op),
        .addr    (eff_addr),
        .tag     (rd_tag),
        .mar     (mar_q),
        .verdict (v)
    );

    // Write port: preload has priority, requests are stalled meanwhile.
    always_comb begin
        wr_en   = 1'b0;
        wr_idx  = acc_idx;
        wr_word = req_wdata;
        wr_tag  = TAG_DATA;
        if (pre_valid) begin
            wr_en   = 1'b1;
            wr_idx  = pre_index;
            wr_word = pre_word;
            wr_tag  = tag_e'(pre_tag);
        end else if (ok && op == OP_STW) begin
            wr_en = 1'b1;
        end else if (ok && op == OP_STB) begin
            wr_en   = 1'b1;
            wr_word = lane_merge(rd_word, lane, req_wdata[7:0]);
        end
    end

    // Response data and cost of the accepted request.
    always_comb begin
        rsp_next = '0;
        cost     = 4'd0;
        if (ok) begin
            unique case (op)
                OP_FETCH: begin
                    rsp_next = rd_word;
                    cost     = 4'(FETCH_COST);
                end
                OP_LDW: begin
                    rsp_next = v.hit ? mdr_q : rd_word;
                    cost     = v.hit ? 4'(HIT_COST) : 4'(MISS_COST);
                end
                OP_LDB: begin
                    rsp_next = {24'd0, lane_pick(rd_word, lane)};
                    cost     = v.hit ? 4'(HIT_COST) : 4'(MISS_COST);
                end
                OP_STW:  cost = 4'(STORE_COST);
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid_q <= 1'b0;
            rsp_data_q  <= '0;
            flt_q       <= 1'b0;
            code_q      <= FLT_RANGE;
            halted_q    <= 1'b0;
            ic_q        <= '1;
            mar_q       <= '1;
            mdr_q       <= '0;
            cyc_q       <= '0;
        end else begin
            rsp_valid_q <= acc && (op == OP_FETCH || op == OP_LDW || op == OP_LDB);
            rsp_data_q  <= rsp_next;
            flt_q       <= acc && v.fault;
            cyc_q       <= cyc_q + CNT_W'(cost);
            if (acc && v.fault) begin
                code_q   <= v.code;
                halted_q <= 1'b1;
            end
            if (ok) begin
                unique case (op)
                    OP_SETPC: ic_q <= req_addr;
                    OP_FETCH: ic_q <= ic_q + 32'd4;
                    OP_LDW: begin
                        if (!v.hit) begin
                            mar_q <= eff_addr[31:2];
                            mdr_q <= rd_word;
                        end
                    end
                    OP_LDB: begin
                        if (!v.hit) mar_q <= eff_addr[31:2];
                        mdr_q <= rd_word;
                    end
                    OP_STW: begin
                        mar_q <= eff_addr[31:2];
                        mdr_q <= req_wdata;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign rsp_valid   = rsp_valid_q;
    assign rsp_data    = rsp_data_q;
    assign fault_pulse = flt_q;
    assign fault_code  = code_q;
    assign halted      = halted_q;
    assign instr_ctr   = ic_q;
    assign cycle_count = cyc_q;

endmodule

// File: rtl/tagmem_sva.sv
module tagmem_sva #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_ready,
    input logic [2:0]       req_op,
    input logic             rsp_valid,
    input logic [31:0]      rsp_data,
    input logic             fault_pulse,
    input logic             halted,
    input logic [CNT_W-1:0] cycle_count
);

    // R12: a halted controller never accepts a request
    assert_halt_blocks_R12: assert property (@(posedge clk) disable iff (rst)
        halted |-> !req_ready);

    // R12: fault pulse comes with the halt flag and lasts one cycle
    assert_fault_halts_R12: assert property (@(posedge clk) disable iff (rst)
        fault_pulse |-> halted);
    assert_fault_single_R12: assert property (@(posedge clk) disable iff (rst)
        fault_pulse |=> !fault_pulse);

    // R14: an accepted fetch or load answers in the next cycle
    assert_rsp_follows_R14: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && (req_op == 3'd0 || req_op == 3'd1 || req_op == 3'd2))
        |=> rsp_valid);

    // R3: a faulting fetch or load returns zero
    assert_fault_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (fault_pulse && rsp_valid) |-> (rsp_data == 32'd0));

    // R6: cycle count steps by 0, 1 or 10 only
    assert_cost_step_R6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((cycle_count - $past(cycle_count)) == CNT_W'(0) ||
                  (cycle_count - $past(cycle_count)) == CNT_W'(1) ||
                  (cycle_count - $past(cycle_count)) == CNT_W'(10)));

endmodule

bind tagmem_ctrl tagmem_sva #(.CNT_W(CNT_W)) u_sva (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_op      (req_op),
    .rsp_valid   (rsp_valid),
    .rsp_data    (rsp_data),
    .fault_pulse (fault_pulse),
    .halted      (halted),
    .cycle_count (cycle_count)
);

// File: tb/sim_tagmem_ctrl.sv
`timescale 1ns/1ps
module sim_tagmem_ctrl;

    localparam int DEPTH = 1024;
    localparam int IDX_W = $clog2(DEPTH);

    localparam logic [2:0] FETCH = 3'd0, LDW = 3'd1, LDB = 3'd2,
                           STW = 3'd3, STB = 3'd4, SETPC = 3'd5;

    typedef struct packed {
        logic [2:0]  op;
        logic [31:0] addr;
        logic [31:0] wd;
        logic        chk;
        logic [31:0] exp;
        logic [31:0] cyc;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{SETPC, 32'd16, 32'h0,        1'b0, 32'h0,        32'd0},
        '{FETCH, 32'd0,  32'h0,        1'b1, 32'hA0000004, 32'd10},
        '{FETCH, 32'd0,  32'h0,        1'b1, 32'hB0000005, 32'd20},
        '{STW,   32'd40, 32'hCAFEF00D, 1'b0, 32'h0,        32'd30},
        '{LDW,   32'd40, 32'h0,        1'b1, 32'hCAFEF00D, 32'd31},
        '{STB,   32'd41, 32'h55,       1'b0, 32'h0,        32'd31},
        '{LDW,   32'd40, 32'h0,        1'b1, 32'hCAFEF00D, 32'd32},
        '{LDB,   32'd41, 32'h0,        1'b1, 32'h55,       32'd33},
        '{LDW,   32'd40, 32'h0,        1'b1, 32'hCAFE550D, 32'd34},
        '{LDW,   32'd16, 32'h0,        1'b1, 32'hA0000004, 32'd44},
        '{LDB,   32'd43, 32'h0,        1'b1, 32'hCA,       32'd54},
        '{STB,   32'd50, 32'h77,       1'b0, 32'h0,        32'd54},
        '{LDW,   32'd48, 32'h0,        1'b1, 32'h00770000, 32'd64},
        '{LDW,   32'd60, 32'h0,        1'b1, 32'h0,        32'd74},
        '{STB,   32'd4,  32'h9A,       1'b0, 32'h0,        32'd74},
        '{LDW,   32'd60, 32'h0,        1'b1, 32'h0,        32'd75},
        '{LDW,   32'd4,  32'h0,        1'b1, 32'h0000009A, 32'd85}
    };

    function automatic string vec_req(int i);
        case (i)
            0, 1, 2:  return "R2";
            3:        return "R10";
            4:        return "R6";
            5:        return "R11";
            6:        return "R7";
            7:        return "R8";
            8, 9:     return "R6";
            10:       return "R8";
            11, 12:   return "R11";
            13:       return "R1";
            default:  return "R11";
        endcase
    endfunction

    logic clk = 1'b0, rst = 1'b1;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [2:0]  req_op = 3'd0;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic pre_valid = 1'b0;
    logic [IDX_W-1:0] pre_index = '0;
    logic [31:0] pre_word = '0;
    logic [1:0]  pre_tag = '0;
    logic rsp_valid, fault_pulse, halted;
    logic [31:0] rsp_data, instr_ctr, cycle_count;
    logic [1:0]  fault_code;

    int n_chk = 0, n_err = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tagmem_ctrl #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
        .pre_valid(pre_valid), .pre_index(pre_index), .pre_word(pre_word),
        .pre_tag(pre_tag), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .fault_pulse(fault_pulse), .fault_code(fault_code), .halted(halted),
        .instr_ctr(instr_ctr), .cycle_count(cycle_count)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // Drive at a falling edge, leave the sampling point 2 ns after the rising edge.
    task automatic issue(input logic [2:0] op, input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = d;
        @(posedge clk);
        #2;
        req_valid = 1'b0;
    endtask

    task automatic preload(input int idx, input logic [31:0] w, input logic [1:0] t);
        @(negedge clk);
        pre_valid = 1'b1; pre_index = IDX_W'(idx); pre_word = w; pre_tag = t;
        @(posedge clk);
        #2;
        pre_valid = 1'b0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        do_reset();
        #1;
        // R1 reset state
        check("R1", "ready",   32'(req_ready),  32'd1);
        check("R1", "halted",  32'(halted),     32'd0);
        check("R1", "cycles",  cycle_count,     32'd0);
        check("R1", "counter", instr_ctr,       32'hFFFFFFFF);
        check("R1", "rsp",     32'(rsp_valid),  32'd0);

        // Vector walk
        preload(4, 32'hA0000004, 2'd1);
        preload(5, 32'hB0000005, 2'd2);
        for (int i = 0; i < NV; i++) begin
            issue(VECS[i].op, VECS[i].addr, VECS[i].wd);
            check("R14", $sformatf("rsp_valid v%0d", i), 32'(rsp_valid), 32'(VECS[i].chk));
            if (VECS[i].chk)
                check(vec_req(i), $sformatf("data v%0d", i), rsp_data, VECS[i].exp);
            check(vec_req(i), $sformatf("cycles v%0d", i), cycle_count, VECS[i].cyc);
            check("R12", $sformatf("no fault v%0d", i), 32'(fault_pulse), 32'd0);
            if (i == 2) check("R2", "counter +4", instr_ctr, 32'd24);
        end

        // R13: preload stalls a request in the same cycle
        @(negedge clk);
        pre_valid = 1'b1; pre_index = IDX_W'(20); pre_word = 32'h0; pre_tag = 2'd3;
        req_valid = 1'b1; req_op = LDW; req_addr = 32'd80;
        #1;
        check("R13", "ready low in preload", 32'(req_ready), 32'd0);
        @(posedge clk);
        #2;
        pre_valid = 1'b0; req_valid = 1'b0;
        check("R13", "no accept", 32'(rsp_valid), 32'd0);

        // R1: fetch at reset counter faults on range
        do_reset();
        issue(FETCH, 32'd0, 32'd0);
        check("R1", "fetch after reset fault", 32'(fault_pulse), 32'd1);
        check("R4", "fetch code", 32'(fault_code), 32'd0);
        check("R1", "cycles unchanged", cycle_count, 32'd0);

        // R3 + R12: illegal fetch, pulse width, blocking
        do_reset();
        issue(LDW, 32'd64, 32'd0);
        check("R1", "undefined reads zero", rsp_data, 32'd0);
        issue(SETPC, 32'd64, 32'd0);
        issue(FETCH, 32'd0, 32'd0);
        check("R3", "illegal fault", 32'(fault_pulse), 32'd1);
        check("R3", "illegal code", 32'(fault_code), 32'd2);
        check("R3", "illegal data", rsp_data, 32'd0);
        check("R12", "halted", 32'(halted), 32'd1);
        check("R12", "ready low", 32'(req_ready), 32'd0);
        issue(LDW, 32'd64, 32'd0);
        check("R12", "pulse one cycle", 32'(fault_pulse), 32'd0);
        check("R12", "blocked rsp", 32'(rsp_valid), 32'd0);
        check("R12", "still halted", 32'(halted), 32'd1);

        // R3: fetch of data word
        do_reset();
        issue(STW, 32'd8, 32'h1234);
        issue(SETPC, 32'd8, 32'd0);
        issue(FETCH, 32'd0, 32'd0);
        check("R3", "data fetch code", 32'(fault_code), 32'd2);
        check("R3", "data fetch fault", 32'(fault_pulse), 32'd1);

        // R4: range boundaries
        do_reset();
        issue(LDW, 32'((DEPTH - 1) * 4), 32'd0);
        check("R4", "last word ok", 32'(fault_pulse), 32'd0);
        issue(LDW, 32'(DEPTH * 4), 32'd0);
        check("R4", "past end fault", 32'(fault_pulse), 32'd1);
        check("R4", "past end code", 32'(fault_code), 32'd0);
        do_reset();
        issue(LDW, 32'h80000001, 32'd0);
        check("R4", "negative code over align", 32'(fault_code), 32'd0);
        check("R4", "negative fault", 32'(fault_pulse), 32'd1);

        // R5: alignment
        do_reset();
        issue(LDB, 32'd3, 32'd0);
        check("R5", "byte load unaligned ok", 32'(fault_pulse), 32'd0);
        issue(LDW, 32'd2, 32'd0);
        check("R5", "word load misaligned", 32'(fault_code), 32'd1);
        check("R5", "word load fault", 32'(fault_pulse), 32'd1);
        do_reset();
        issue(STW, 32'd5, 32'd7);
        check("R5", "word store misaligned", 32'(fault_code), 32'd1);
        check("R5", "store cycles", cycle_count, 32'd0);

        // R9: overwrite protection
        do_reset();
        preload(3, 32'h12345678, 2'd1);
        issue(STB, 32'd13, 32'hEE);
        check("R9", "byte store overwrite", 32'(fault_code), 32'd3);
        check("R9", "byte store fault", 32'(fault_pulse), 32'd1);
        check("R9", "no cycles", cycle_count, 32'd0);
        do_reset();
        preload(3, 32'h12345678, 2'd2);
        issue(STW, 32'd12, 32'hEE);
        check("R9", "word store overwrite", 32'(fault_code), 32'd3);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule